// File: doc/BRIEF.md
# Oversampled SPI Target Interface

This block is an SPI target (slave) that runs entirely on the fast system clock. The select, serial clock and serial data-in pins are treated as asynchronous inputs. Each passes through a two-flop synchronizer. The block then finds the edges of the serial clock by comparing each sample with the one before it. Bit counting, both shift registers and the framing state machine all run on the system clock, so the serial side needs no clock domain of its own.

The block works in SPI mode 0, most significant bit first. The master drives data on the falling serial clock edge and samples on the rising edge. On the system side, each received byte appears on `rx_data` together with a one-cycle `rx_strobe`. The byte to send is presented on `tx_data`, and the block acknowledges each capture with a one-cycle `tx_taken` pulse. The serial output and its enable are driven from system-clock registers. They lag the serial clock by a few system cycles, which mode 0 tolerates when the system clock is at least eight times faster than the serial clock.

The framing engine has four states:
- IDLE: waiting for select to go active.
- ARM: capture the first transmit byte.
- SHIFT: count the rising edges of one byte.
- RELOAD: wait for the falling edge that closes the byte, then capture the next transmit byte.

Its transitions are:
- IDLE to ARM when a falling edge of the synchronized select is seen.
- ARM to SHIFT unconditionally.
- SHIFT to RELOAD on the eighth rising edge.
- RELOAD to SHIFT on the next falling edge.
- Any state to IDLE whenever the synchronized select is inactive (high).

Top module: `spi_os_target`

## Requirements
- R1: Select, serial clock and data-in each pass through two system-clock flops before use. After `cs_n_pin` falls, `so_en` rises exactly three system clock edges later.
- R2: Data-in is sampled on each detected rising edge of the serial clock, most significant bit first. The assembled byte appears on `rx_data` when `rx_strobe` is high.
- R3: `so` carries the transmit byte most significant bit first. The MSB is present before the first rising edge. Each following bit changes only on a detected falling edge. The falling edge after the eighth rising edge presents the MSB of the next byte.
- R4: `rx_strobe` is a one-cycle pulse raised exactly three system edges after the eighth rising serial clock edge of a byte, once per byte.
- R5: `tx_data` is captured when a frame starts and again at the falling edge that closes each byte. Every capture is followed by a one-cycle `tx_taken` pulse, giving N+1 pulses for an N-byte frame.
- R6: Select going inactive (high) clears the bit counter and discards a partial byte. No `rx_strobe` is raised for it, and the next frame starts from bit 0.
- R7: While select is inactive, `so` and `so_en` are both low from the cycle after the synchronized select goes high.
- R8: Synchronous reset (`rst` high) clears the synchronizers, the counter and the shift registers. After reset, `rx_data` = 0, `rx_strobe` = 0, `tx_taken` = 0, `so` = 0 and `so_en` = 0.
- R9: Correct operation requires at least 4 system clock cycles between successive serial clock edges. This margin is checked on the detected edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n_pin | input | 1 | Select from master, active low, asynchronous |
| sclk_pin | input | 1 | Serial clock from master, asynchronous, sampled as data |
| si_pin | input | 1 | Serial data from master, asynchronous |
| rx_data | output | 8 | Last received byte |
| rx_strobe | output | 1 | One-cycle pulse: `rx_data` holds a new byte |
| tx_data | input | 8 | Next byte to send |
| tx_taken | output | 1 | One-cycle pulse after `tx_data` has been captured |
| so | output | 1 | Serial data to master |
| so_en | output | 1 | Output enable for the serial data pin |

## Verification
The assertions assume that serial clock edges are at least four system cycles apart. They also assume the serial clock idles low whenever select is inactive, so that edges only occur inside a frame. The stimulus changes every pin on the falling system clock edge. It draws each serial half-period at random from four to seven system cycles, with one directed frame held at exactly four. It keeps the serial clock low around every select change. Beyond these limits the block is not expected to work.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

    // Framing engine states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARM    = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_RELOAD = 2'd3
    } frame_state_t;

endpackage

// File: rtl/spi_os_sync.sv
// Multi-stage synchronizer for a group of asynchronous pins.
module spi_os_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_os_edge.sv
// Edge finder on a synchronized level; optional spacing monitor.
module spi_os_edge #(
    parameter int MIN_HALF  = 4,
    parameter bit CHECK_GAP = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

    if (CHECK_GAP) begin : g_gap
        localparam int GW = $clog2(MIN_HALF + 1);
        localparam logic [GW-1:0] GAP_MAX = GW'(MIN_HALF);

        logic [GW-1:0] gap;

        always_ff @(posedge clk) begin
            if (rst)               gap <= GAP_MAX;
            else if (rise || fall) gap <= GW'(1);
            else if (gap < GAP_MAX) gap <= gap + 1'b1;
        end

        // R9: edges of the serial clock are spaced by at least MIN_HALF cycles
        p_half_margin_r9: assert property (@(posedge clk) disable iff (rst)
            (rise || fall) |-> (gap >= GAP_MAX));
    end

endmodule

// File: rtl/spi_os_engine.sv
// Framing state machine with receive and transmit shift registers.
module spi_os_engine
    import spi_os_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_act,
    input  logic         sel_start,
    input  logic         sck_rise,
    input  logic         sck_fall,
    input  logic         sdi,
    input  logic [W-1:0] tx_data,
    output logic [W-1:0] rx_data,
    output logic         rx_strobe,
    output logic         tx_taken,
    output logic         so,
    output logic         so_en
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    frame_state_t  state, nxt;
    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  rx_sr;
    logic [W-1:0]  tx_sr;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        if (!sel_act) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (sel_start) nxt = ST_ARM;
                ST_ARM:    nxt = ST_SHIFT;
                ST_SHIFT:  if (sck_rise && bit_cnt == LAST) nxt = ST_RELOAD;
                ST_RELOAD: if (sck_fall) nxt = ST_SHIFT;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // Datapath and registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            rx_data   <= '0;
            rx_strobe <= 1'b0;
            tx_taken  <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            tx_taken  <= 1'b0;
            if (!sel_act) begin
                bit_cnt <= '0;
                rx_sr   <= '0;
                tx_sr   <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        bit_cnt <= '0;
                        rx_sr   <= '0;
                        tx_sr   <= '0;
                    end
                    ST_ARM: begin
                        tx_sr    <= tx_data;
                        tx_taken <= 1'b1;
                    end
                    ST_SHIFT: begin
                        if (sck_rise) begin
                            rx_sr <= {rx_sr[W-2:0], sdi};
                            if (bit_cnt == LAST) begin
                                rx_data   <= {rx_sr[W-2:0], sdi};
                                rx_strobe <= 1'b1;
                                bit_cnt   <= '0;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end else if (sck_fall && bit_cnt != '0) begin
                            tx_sr <= {tx_sr[W-2:0], 1'b0};
                        end
                    end
                    ST_RELOAD: begin
                        if (sck_fall) begin
                            tx_sr    <= tx_data;
                            tx_taken <= 1'b1;
                        end
                    end
                    default: bit_cnt <= '0;
                endcase
            end
        end
    end

    assign so_en = (state != ST_IDLE);
    assign so    = so_en & tx_sr[W-1];

    // R4: receive strobe lasts one cycle
    p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> !rx_strobe);

    // R5: capture acknowledge lasts one cycle
    p_taken_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        tx_taken |=> !tx_taken);

    // R2: a byte is only completed by a rising serial clock edge
    p_strobe_after_rise_r2: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |-> $past(sck_rise));

    // R3: within a frame, serial output moves only after a falling edge or a capture
    p_so_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (so_en && $past(so_en) && !$stable(so) && !tx_taken) |-> $past(sck_fall));

    // R6: inactive select never completes a byte
    p_abort_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        !sel_act |=> !rx_strobe);

endmodule

// File: rtl/spi_os_target.sv
// Oversampled SPI target: all logic on the system clock.
module spi_os_target
    import spi_os_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HALF    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_pin,
    input  logic              sclk_pin,
    input  logic              si_pin,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_strobe,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_taken,
    output logic              so,
    output logic              so_en
);

    localparam int NPINS = 3;

    logic [NPINS-1:0] pins_sync;
    logic s_cs_n, s_sclk, s_si;
    logic sck_rise, sck_fall;
    logic cs_rise, cs_fall;

    spi_os_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n_pin, sclk_pin, si_pin}),
        .q   (pins_sync)
    );

    assign {s_cs_n, s_sclk, s_si} = pins_sync;

    spi_os_edge #(.MIN_HALF(MIN_HALF), .CHECK_GAP(1'b1)) u_sck_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (s_sclk),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    spi_os_edge #(.MIN_HALF(MIN_HALF), .CHECK_GAP(1'b0)) u_cs_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (s_cs_n),
        .rise (cs_rise),
        .fall (cs_fall)
    );

    spi_os_engine #(.W(WORD_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .sel_act   (~s_cs_n),
        .sel_start (cs_fall),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sdi       (s_si),
        .tx_data   (tx_data),
        .rx_data   (rx_data),
        .rx_strobe (rx_strobe),
        .tx_taken  (tx_taken),
        .so        (so),
        .so_en     (so_en)
    );

    // R7: synchronized select high silences the pin on the next cycle
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        s_cs_n |=> (!so_en && !so));

    // R7: the end of a frame releases the output enable
    p_stop_release_r7: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> !so_en);

endmodule

// File: tb/spi_os_target_test.sv
`timescale 1ns/1ps
module spi_os_target_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n_pin, sclk_pin, si_pin;
    logic [7:0] rx_data, tx_data;
    logic       rx_strobe, tx_taken, so, so_en;

    always #4 clk = ~clk; // 125 MHz

    spi_os_target uut (
        .clk       (clk),
        .rst       (rst),
        .cs_n_pin  (cs_n_pin),
        .sclk_pin  (sclk_pin),
        .si_pin    (si_pin),
        .rx_data   (rx_data),
        .rx_strobe (rx_strobe),
        .tx_data   (tx_data),
        .tx_taken  (tx_taken),
        .so        (so),
        .so_en     (so_en)
    );

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int taken_seen, strobe_seen, strobe_cyc, rise_cyc, tx_ptr;
    int min_half = 1000;
    bit done = 1'b0;
    logic [7:0] cap_byte;
    logic [7:0] mosi_q [8];
    logic [7:0] tx_q   [8];
    logic [7:0] miso_got [8];

    function automatic logic [7:0] rand_byte();
        return 8'($urandom_range(255, 0));
    endfunction

    function automatic int pick_half(input int lo, input int hi);
        return (lo == hi) ? lo : int'($urandom_range(hi, lo));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (tx_taken) begin
            taken_seen++;
            if (tx_ptr < 7) tx_ptr++;
            tx_data = tx_q[tx_ptr];
        end
        if (rx_strobe) begin
            strobe_seen++;
            strobe_cyc = cyc;
            cap_byte   = rx_data;
        end
    endtask

    // Full frame when cut == 0, otherwise abort after cut bits
    task automatic send_frame(input int nbytes, input int lo, input int hi, input int cut);
        int h;
        int total;
        tx_ptr = 0;
        tx_data = tx_q[0];
        taken_seen = 0;
        strobe_seen = 0;
        strobe_cyc = -100;
        cs_n_pin = 1'b0;
        tick(); tick();
        check(so_en == 1'b0, "R1 early", int'(so_en), 0);
        tick();
        check(so_en == 1'b1, "R1 enable", int'(so_en), 1);
        tick(); tick(); tick();
        total = (cut > 0) ? cut : nbytes * 8;
        for (int b = 0; b < total; b++) begin
            int by = b / 8;
            int bi = 7 - (b % 8);
            si_pin = mosi_q[by][bi];
            h = pick_half(lo, hi);
            if (h < min_half) min_half = h;
            repeat (h) tick();
            miso_got[by][bi] = so;
            sclk_pin = 1'b1;
            rise_cyc = cyc;
            h = pick_half(lo, hi);
            if (h < min_half) min_half = h;
            repeat (h) tick();
            if (bi == 0 && cut == 0) begin
                check(strobe_cyc == rise_cyc + 3 && strobe_seen == by + 1, "R4 strobe timing",
                      strobe_cyc - rise_cyc, 3);
                check(cap_byte == mosi_q[by], "R2 rx byte", int'(cap_byte), int'(mosi_q[by]));
            end
            sclk_pin = 1'b0;
        end
        h = pick_half(lo, hi);
        if (h < min_half) min_half = h;
        repeat (h) tick();
        cs_n_pin = 1'b1;
        repeat (3) tick();
        check(so_en == 1'b0 && so == 1'b0, "R7 idle", int'({so_en, so}), 0);
        repeat (4) tick();
        if (cut > 0) begin
            check(strobe_seen == 0, "R6 abort", strobe_seen, 0);
        end else begin
            for (int by = 0; by < nbytes; by++)
                check(miso_got[by] == tx_q[by], "R3 so byte", int'(miso_got[by]), int'(tx_q[by]));
            check(taken_seen == nbytes + 1, "R5 captures", taken_seen, nbytes + 1);
            check(strobe_seen == nbytes, "R4 strobe count", strobe_seen, nbytes);
        end
    endtask

    task automatic fill_random(input int n);
        for (int i = 0; i < 8; i++) begin
            mosi_q[i] = rand_byte();
            tx_q[i]   = rand_byte();
        end
    endtask

    initial begin
        int seed_init;
        seed_init = int'($urandom(32'd91357));
        rst = 1'b1;
        cs_n_pin = 1'b1;
        sclk_pin = 1'b0;
        si_pin = 1'b0;
        tx_data = 8'h00;
        tx_ptr = 0;
        for (int i = 0; i < 8; i++) begin
            mosi_q[i] = 8'h00;
            tx_q[i] = 8'h00;
        end
        repeat (4) @(negedge clk);
        // R8: reset state
        check(rx_data == 8'h00 && !rx_strobe && !tx_taken && !so && !so_en, "R8 reset",
              int'({rx_data, rx_strobe, tx_taken, so, so_en}), 0);
        rst = 1'b0;
        repeat (6) tick();
        check(so_en == 1'b0 && so == 1'b0, "R7 after reset", int'({so_en, so}), 0);

        // Directed: tightest margin, extreme patterns (R2, R3, R9)
        mosi_q[0] = 8'h00; mosi_q[1] = 8'hFF; mosi_q[2] = 8'hA5;
        tx_q[0] = 8'hFF;   tx_q[1] = 8'h00;   tx_q[2] = 8'h5A; tx_q[3] = 8'h81;
        send_frame(3, 4, 4, 0);

        // Directed: abort after 1 and after 7 bits, then a clean frame (R6)
        fill_random(8);
        send_frame(1, 4, 6, 1);
        send_frame(1, 4, 6, 7);
        mosi_q[0] = 8'h3C; tx_q[0] = 8'hC3;
        send_frame(1, 4, 6, 0);

        // Random frames
        for (int f = 0; f < 12; f++) begin
            fill_random(8);
            send_frame(int'($urandom_range(5, 1)), 4, 7, 0);
        end

        check(min_half >= 4, "R9 margin", min_half, 4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule